// File: doc/BRIEF.md
# Byte-Wide Host Register Bus Slave

This block lets a host processor read and write a small bank of byte registers over an asynchronous, Intel-style parallel bus. The host places an address on the address pins and pulses an active-high latch strobe. The address is captured when that strobe falls. It then lowers either the read or the write strobe while chip select is low. Every strobe passes through a synchroniser into the core clock domain. An active-low ready output holds the host in wait states until the access has been carried out.

Reads drive the addressed byte onto a shared tri-state data bus, but only while chip select and the read strobe are both low. Writes store the byte that is on the bus when the write strobe rises. Register 0 holds interrupt status bits. Core-side event pulses set these bits, and the host clears them by writing ones. Register 1 is the interrupt enable mask. An open-drain, active-low interrupt line is pulled low whenever an enabled status bit is set. A rising latch strobe under chip select also produces a one-cycle burst-start flag.

Top module: `hostbus_regslave`

## Requirements
- R1: After reset the ready output is high, the interrupt line is released, the data bus is not driven, the burst flag is low and every register reads 0x00.
- R2: The register accessed is the one whose address was on the bus when the latch strobe fell. Address pin changes after that fall have no effect on the access.
- R3: A rising latch strobe while chip select is low gives exactly one single-cycle burst_start pulse. With chip select high it gives none.
- R4: The data bus is driven only while both bus_rd_n and bus_cs_n are low. At all other times it is high impedance, including a read strobe with chip select high.
- R5: A selected write stores the byte present on the data bus just before bus_wr_n rises into the latched register.
- R6: With default parameters, bus_rdy_n goes low on the 5th rising clock edge (SYNC_STAGES + 1 + WAIT_CYC) after a selected read or write strobe falls. It returns high on the 3rd edge (SYNC_STAGES + 1) after both strobes are high again.
- R7: While bus_cs_n is high, read and write strobes are ignored: ready stays high, no register changes and the bus is not driven.
- R8: Addresses at or above NUM_REGS (16) read 0x00 and ignore writes, and the ready handshake still completes.
- R9: Register 0 is the interrupt status register. A 1 on irq_src[i] for one clock sets bit i, and the bit stays set until the host writes a 1 to it. Writing 0 to a bit leaves it unchanged. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: irq_n is driven low exactly when (register 0 AND register 1) is nonzero. Otherwise it is released (high impedance).
- R11: Registers 2 to 15 are plain read/write bytes that read back the last value written.
- R12: Register 1, the interrupt enable mask, reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_ale | input | 1 | Active-high address latch strobe |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_addr | input | ADDR_W (9) | Register address |
| bus_data | inout | 8 | Bidirectional data bus |
| bus_rdy_n | output | 1 | Active-low ready / wait-state release |
| irq_n | output | 1 | Open-drain active-low interrupt request |
| burst_start | output | 1 | One-cycle flag on a selected latch strobe |
| irq_src | input | 8 | Core-domain interrupt event pulses |

## Verification
The bench moves the address pins to a random value right after each latch. A design that sampled the address late would then write or read the wrong register. It counts clock edges from each strobe edge to the ready transitions, which exposes a missing or extra wait or synchroniser stage. It issues strobes with chip select high and expects no ready, no write and a floating bus. A block that ignored select would corrupt registers or fight the bus. It also targets write-one-to-clear against held status bits, masked versus unmasked interrupt sources, and the aliases of registers 0 and 5 above address 15. A design with a truncated address decode would overwrite those low registers.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
   localparam int DATA_W   = 8;
   localparam int REG_STAT = 0;
   localparam int REG_MASK = 1;

   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_WAIT = 2'd1,
      CYC_DONE = 2'd2
   } cyc_state_e;

   typedef struct packed {
      logic cs_n;
      logic ale;
      logic rd_n;
      logic wr_n;
   } strobes_t;

   localparam strobes_t STROBES_IDLE = '{cs_n: 1'b1, ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbs_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[s-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/hbs_cycle_ctl.sv
module hbs_cycle_ctl
   import hbs_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int WAIT_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobes_t          strb_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] data_s,
   output logic [ADDR_W-1:0] addr_lat,
   output logic              burst_start,
   output logic              reg_we,
   output logic [DATA_W-1:0] wr_data,
   output logic              rdy_n,
   output logic              wait_busy
);
   localparam int CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("hbs_cycle_ctl: WAIT_CYC must be at least 1");
   end

   strobes_t          prev_q;
   logic [ADDR_W-1:0] addr_hold_q;
   logic [DATA_W-1:0] wdata_hold_q;
   cyc_state_e        state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic              op_wr_q, op_wr_d;
   logic              burst_q;

   logic sel, ale_rise, ale_fall, rd_fall, wr_fall, wr_rise, both_high;

   assign sel       = ~strb_s.cs_n;
   assign ale_rise  =  strb_s.ale  & ~prev_q.ale;
   assign ale_fall  = ~strb_s.ale  &  prev_q.ale;
   assign rd_fall   = ~strb_s.rd_n &  prev_q.rd_n;
   assign wr_fall   = ~strb_s.wr_n &  prev_q.wr_n;
   assign wr_rise   =  strb_s.wr_n & ~prev_q.wr_n;
   assign both_high =  strb_s.rd_n &  strb_s.wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q       <= STROBES_IDLE;
         addr_hold_q  <= '0;
         addr_lat     <= '0;
         wdata_hold_q <= '0;
         burst_q      <= 1'b0;
      end else begin
         prev_q  <= strb_s;
         burst_q <= ale_rise & sel;
         if (strb_s.ale)   addr_hold_q  <= addr_s;
         if (ale_fall)     addr_lat     <= addr_hold_q;
         if (!strb_s.wr_n) wdata_hold_q <= data_s;
      end
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      op_wr_d = op_wr_q;
      unique case (state_q)
         CYC_IDLE: begin
            if (sel && (rd_fall || wr_fall)) begin
               state_d = CYC_WAIT;
               cnt_d   = '0;
               op_wr_d = wr_fall;
            end
         end
         CYC_WAIT: begin
            if (cnt_q == CNT_LAST) state_d = CYC_DONE;
            else                   cnt_d   = cnt_q + 1'b1;
         end
         CYC_DONE: begin
            if (both_high) state_d = CYC_IDLE;
         end
         default: state_d = CYC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CYC_IDLE;
         cnt_q   <= '0;
         op_wr_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         op_wr_q <= op_wr_d;
      end
   end

   assign reg_we      = wr_rise & op_wr_q & (state_q != CYC_IDLE);
   assign wr_data     = wdata_hold_q;
   assign rdy_n       = (state_q != CYC_DONE);
   assign wait_busy   = (state_q == CYC_WAIT);
   assign burst_start = burst_q;
endmodule

// File: rtl/hbs_regfile.sv
module hbs_regfile
   import hbs_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] irq_src,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] stat_val,
   output logic              irq_pend
);
   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("hbs_regfile: NUM_REGS must be a power of two, at least 2");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("hbs_regfile: NUM_REGS exceeds the address space");
   end

   logic              hit;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] stat_q, mask_q, w1c;
   logic [DATA_W-1:0] rd_vec [NUM_REGS];

   assign hit = ((addr >> IDX_W) == '0);
   assign idx = addr[IDX_W-1:0];
   assign w1c = (we && hit && idx == IDX_W'(REG_STAT)) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
      end else begin
         stat_q <= (stat_q & ~w1c) | irq_src;
         if (we && hit && idx == IDX_W'(REG_MASK)) mask_q <= wdata;
      end
   end

   assign rd_vec[REG_STAT] = stat_q;
   assign rd_vec[REG_MASK] = mask_q;

   for (genvar i = 2; i < NUM_REGS; i++) begin : g_gen
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             r <= '0;
         else if (we && hit && idx == IDX_W'(i)) r <= wdata;
      end
      assign rd_vec[i] = r;
   end

   assign rdata    = hit ? rd_vec[idx] : '0;
   assign stat_val = stat_q;
   assign irq_pend = |(stat_q & mask_q);
endmodule

// File: rtl/hostbus_regslave.sv
module hostbus_regslave
   import hbs_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int NUM_REGS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int WAIT_CYC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_ale,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic [ADDR_W-1:0] bus_addr,
   inout  wire  [7:0]        bus_data,
   output logic              bus_rdy_n,
   output wire               irq_n,
   output logic              burst_start,
   input  logic [7:0]        irq_src
);
   if (DATA_W != 8) begin : g_bad_width
      $error("hostbus_regslave: data bus must be one byte");
   end

   strobes_t          strb_raw, strb_s;
   logic [ADDR_W-1:0] addr_s, addr_lat;
   logic [DATA_W-1:0] data_s, wr_data, rd_data, stat_val;
   logic              reg_we, wait_busy, irq_pend, drive_en;

   assign strb_raw = '{cs_n: bus_cs_n, ale: bus_ale, rd_n: bus_rd_n, wr_n: bus_wr_n};

   hbs_sync #(.W($bits(strobes_t)), .STAGES(SYNC_STAGES), .RST_VAL(STROBES_IDLE)) u_sync_strb (
      .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s));

   hbs_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
      .clk(clk), .rst_n(rst_n), .d(bus_addr), .q(addr_s));

   hbs_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .d(bus_data), .q(data_s));

   hbs_cycle_ctl #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_ctl (
      .clk(clk), .rst_n(rst_n), .strb_s(strb_s), .addr_s(addr_s), .data_s(data_s),
      .addr_lat(addr_lat), .burst_start(burst_start), .reg_we(reg_we),
      .wr_data(wr_data), .rdy_n(bus_rdy_n), .wait_busy(wait_busy));

   hbs_regfile #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(addr_lat), .wdata(wr_data),
      .irq_src(irq_src), .rdata(rd_data), .stat_val(stat_val), .irq_pend(irq_pend));

   // The output enable follows the raw pins so the bus frees as soon as the host lets go.
   assign drive_en = ~bus_rd_n & ~bus_cs_n;
   assign bus_data = drive_en ? rd_data : 8'hzz;
   assign irq_n    = irq_pend ? 1'b0 : 1'bz;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker
   import hbs_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              burst_start,
   input logic              bus_rdy_n,
   input logic              reg_we,
   input logic              ale_sync,
   input logic              rd_sync,
   input logic              wr_sync,
   input logic              wait_busy,
   input logic [ADDR_W-1:0] addr_lat,
   input logic [DATA_W-1:0] irq_src,
   input logic [DATA_W-1:0] stat_val
);
   AST_BURST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) burst_start |=> !burst_start); // R3
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ale_sync |=> $stable(addr_lat)); // R2
   AST_WRITE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n) reg_we |-> $past(!wr_sync)); // R5
   AST_RDY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_rdy_n) |-> $past(wait_busy)); // R6
   AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (!bus_rdy_n && rd_sync && wr_sync) |=> bus_rdy_n); // R6
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq_src != '0) |=> ((stat_val & $past(irq_src)) == $past(irq_src))); // R9
endmodule

bind hostbus_regslave hbs_checker #(.ADDR_W(ADDR_W)) u_hbs_checker (
   .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .bus_rdy_n(bus_rdy_n),
   .reg_we(reg_we), .ale_sync(strb_s.ale), .rd_sync(strb_s.rd_n), .wr_sync(strb_s.wr_n),
   .wait_busy(wait_busy), .addr_lat(addr_lat), .irq_src(irq_src), .stat_val(stat_val));

// File: tb/test_hostbus_regslave.sv
module test_hostbus_regslave;
   localparam int ADDR_W      = 9;
   localparam int NUM_REGS    = 16;
   localparam int SYNC_STAGES = 2;
   localparam int WAIT_CYC    = 2;
   localparam int RDY_EDGES   = SYNC_STAGES + 1 + WAIT_CYC;
   localparam int REL_EDGES   = SYNC_STAGES + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              cs_n = 1'b1, ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic              tb_drv = 1'b0;
   logic [7:0]        tb_dat = '0;
   logic [7:0]        irq_src = '0;
   wire  [7:0]        bus_data;
   wire               irq_line;
   wire               rdy_n;
   wire               burst_start;

   assign bus_data = tb_drv ? tb_dat : 8'hzz;
   for (genvar g = 0; g < 8; g++) begin : g_pu
      pullup pu_d (bus_data[g]);
   end
   pullup pu_irq (irq_line);

   hostbus_regslave #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES),
                      .WAIT_CYC(WAIT_CYC)) i_hostbus_regslave (
      .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_ale(ale), .bus_rd_n(rd_n),
      .bus_wr_n(wr_n), .bus_addr(addr), .bus_data(bus_data), .bus_rdy_n(rdy_n),
      .irq_n(irq_line), .burst_start(burst_start), .irq_src(irq_src));

   int checks = 0;
   int fails = 0;
   int burst_cnt = 0;
   logic [7:0] m_reg [NUM_REGS];

   always @(negedge clk) if (burst_start === 1'b1) burst_cnt++;

   task automatic tick();
      @(negedge clk);
      #2;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   function automatic logic [7:0] exp_read(input logic [ADDR_W-1:0] a);
      return (a < NUM_REGS) ? m_reg[a[3:0]] : 8'h00;
   endfunction

   task automatic check_irq();
      logic exp_v;
      exp_v = ((m_reg[0] & m_reg[1]) != 0) ? 1'b0 : 1'b1;
      chk(irq_line === exp_v, "R10 irq line", {31'd0, irq_line}, {31'd0, exp_v});
   endtask

   task automatic latch_addr(input logic [ADDR_W-1:0] a, input bit sel);
      int b0;
      b0 = burst_cnt;
      cs_n = !sel;
      addr = a;
      ale  = 1'b1;
      repeat (3) tick();
      ale  = 1'b0;
      repeat (SYNC_STAGES + 2) tick();
      addr = ADDR_W'($urandom);   // R2: pins move after the latch
      chk((burst_cnt - b0) == (sel ? 1 : 0), "R3 burst pulses", burst_cnt - b0, sel ? 1 : 0);
   endtask

   task automatic wait_ready(input bit sel);
      int n;
      n = 0;
      for (int i = 1; i <= 12; i++) begin
         tick();
         if (rdy_n === 1'b0) begin
            n = i;
            break;
         end
      end
      if (sel) chk(n == RDY_EDGES, "R6 ready edges", n, RDY_EDGES);
      else     chk(n == 0, "R7 no ready unselected", n, 0);
   endtask

   task automatic wait_release();
      int n;
      n = 0;
      for (int i = 1; i <= 12; i++) begin
         tick();
         if (rdy_n === 1'b1) begin
            n = i;
            break;
         end
      end
      chk(n == REL_EDGES, "R6 ready release edges", n, REL_EDGES);
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit sel);
      latch_addr(a, sel);
      tb_dat = d;
      tb_drv = 1'b1;
      tick();
      wr_n = 1'b0;
      wait_ready(sel);
      wr_n = 1'b1;
      if (sel) wait_release();
      repeat (SYNC_STAGES + 2) tick();
      tb_drv = 1'b0;
      cs_n   = 1'b1;
      repeat (2) tick();
      if (sel && a < NUM_REGS) begin
         if (a == 0) m_reg[0] = m_reg[0] & ~d;
         else        m_reg[a[3:0]] = d;
      end
      check_irq();
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, input bit sel, input string req);
      logic [7:0] got, exp_v;
      latch_addr(a, sel);
      rd_n = 1'b0;
      wait_ready(sel);
      if (!sel) repeat (2) tick();
      got   = bus_data;
      exp_v = sel ? exp_read(a) : 8'hFF;
      chk(got === exp_v, req, got, exp_v);
      rd_n = 1'b1;
      #1;
      chk(bus_data === 8'hFF, "R4 bus released after read", bus_data, 8'hFF);
      if (sel) wait_release();
      cs_n = 1'b1;
      repeat (2) tick();
      check_irq();
   endtask

   task automatic irq_pulse(input logic [7:0] v);
      irq_src = v;
      tick();
      irq_src = '0;
      tick();
      m_reg[0] = m_reg[0] | v;
      check_irq();
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      for (int i = 0; i < NUM_REGS; i++) m_reg[i] = '0;
      void'($urandom(32'd4711));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      chk(rdy_n === 1'b1, "R1 ready after reset", {31'd0, rdy_n}, 1);
      chk(irq_line === 1'b1, "R1 irq released after reset", {31'd0, irq_line}, 1);
      chk(bus_data === 8'hFF, "R1 bus floating after reset", bus_data, 8'hFF);
      chk(burst_start === 1'b0, "R1 burst flag after reset", {31'd0, burst_start}, 0);
      do_read(9'd5, 1'b1, "R1 register zero after reset");
      do_read(9'd0, 1'b1, "R1 status zero after reset");

      do_write(9'd5, 8'h5A, 1'b1);
      do_read(9'd5, 1'b1, "R11 readback reg5");
      do_write(9'd15, 8'hC3, 1'b1);
      do_read(9'd15, 1'b1, "R11 readback top reg");

      do_write(9'd6, 8'h33, 1'b1);
      do_read(9'd6, 1'b1, "R2 latched target reg6");
      do_read(9'd7, 1'b1, "R2 neighbour reg7 untouched");

      do_read(9'd5, 1'b0, "R4 no drive without select");
      do_write(9'd5, 8'h00, 1'b0);
      do_read(9'd5, 1'b1, "R7 write ignored without select");

      do_write(9'h105, 8'h77, 1'b1);
      do_read(9'h105, 1'b1, "R8 unimplemented reads zero");
      do_read(9'd5, 1'b1, "R8 alias reg5 unchanged");
      do_write(9'h1F0, 8'hFF, 1'b1);
      do_read(9'd0, 1'b1, "R8 alias status unchanged");

      do_write(9'd1, 8'h0F, 1'b1);
      do_read(9'd1, 1'b1, "R12 mask readback");
      irq_pulse(8'h30);
      do_read(9'd0, 1'b1, "R9 status bits set");
      irq_pulse(8'h01);
      do_write(9'd0, 8'h10, 1'b1);
      do_read(9'd0, 1'b1, "R9 write one clears bit4 only");
      do_write(9'd0, 8'h01, 1'b1);
      do_read(9'd0, 1'b1, "R9 clear enabled bit");
      do_write(9'd0, 8'hFF, 1'b1);
      do_read(9'd0, 1'b1, "R9 status all clear");

      for (int n = 0; n < 120; n++) begin
         int op;
         logic [ADDR_W-1:0] a;
         op = $urandom_range(0, 9);
         a  = ($urandom_range(0, 3) == 0) ? ADDR_W'($urandom) : ADDR_W'($urandom_range(0, NUM_REGS - 1));
         if (op < 4)       do_write(a, 8'($urandom), 1'b1);
         else if (op < 8)  do_read(a, 1'b1, "R11 random readback");
         else              irq_pulse(8'($urandom) & 8'($urandom));
      end
      report();
   end
endmodule